// File: doc/BRIEF.md
# Audio CPU I/O Page Decoder with Switchable Boot ROM

This block sits between a small audio processor and its 64 KB memory. It watches every CPU access, sends ordinary accesses to an external RAM, and serves a sixteen-byte register page at 0x00F0 to 0x00FF by itself. That page holds a test location, a control register, an index/data pair that reaches into a separate sound DSP, and four byte-wide communication ports that the host side of the chip can see. The remaining page locations are forwarded to RAM and are handled there or by a neighbouring timer block.

The top 64 bytes of the address space, 0xFFC0 to 0xFFFF, can be covered by a built-in boot image. Every write into that window is always captured in a private 64-byte shadow store. The write reaches the external RAM only while the image is switched off. Switching the image off exposes the shadow contents, and switching it back on brings back the boot image. One control write can change the boot-image state, set the three timer enables and zero either or both pairs of communication ports in the same cycle.

Reads complete one cycle after the strobe. The external RAM and the DSP are both expected to return read data on the clock edge after their read enable.

Top module: `iopage_ctrl`

## Requirements
- R1: After reset the boot image is switched on, `timer_en` is 0, all four ports in `comm_ports` are 0 and `dsp_index` is 0.
- R2: While the boot image is on, a read of 0xFFC0+i returns image byte i. Bytes 62 and 63 are 0xC0 and 0xFF. Every other byte is ((29*i) mod 256) XOR 0xA5.
- R3: A write into 0xFFC0 to 0xFFFF always updates shadow byte i. It raises `ram_we` only when the boot image is off.
- R4: While the boot image is off, a read of 0xFFC0+i returns the last value written to shadow byte i. Turning the image back on makes the same reads return image bytes again.
- R5: A write to 0x00F1 sets the boot-image state from data bit 7 (1 = on) and sets `timer_en` to data bits 2..0.
- R6: A write to 0x00F4+k (k = 0..3) stores the byte in port k, which appears at `comm_ports[8k+7:8k]` and reads back at the same address. A write to 0x00F1 with bit 4 set zeroes ports 0 and 1. The same write with bit 5 set zeroes ports 2 and 3.
- R7: 0x00F2 is a read/write index register, and `dsp_index` carries its low 7 bits. A read of 0x00F3 raises `dsp_re` and returns `dsp_rdata`. A write of 0x00F3 raises `dsp_we` with the data on `dsp_wdata`. `ram_we` and `dsp_we` are never high together.
- R8: A write to 0x00F0 changes nothing: no RAM or DSP strobe, and no change to ports, timers or the boot-image state. Reads of 0x00F0 and 0x00F1 return 0.
- R9: Addresses below 0x00F0, addresses 0x00F8 to 0x00FF, and all addresses from 0x0100 to 0xFFBF go to the external RAM. Writes raise `ram_we`, and reads raise `ram_re` and return `ram_rdata`.
- R10: A read (`cpu_rd` high, `cpu_wr` low) raises `cpu_rvalid` on the following cycle only, with `cpu_rdata` valid then. A cycle that has both strobes high is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| ram_addr | output | 16 | External RAM address |
| ram_wdata | output | 8 | External RAM write data |
| ram_we | output | 1 | External RAM write enable |
| ram_re | output | 1 | External RAM read enable |
| ram_rdata | input | 8 | External RAM read data, one cycle after ram_re |
| dsp_index | output | 7 | DSP register index |
| dsp_wdata | output | 8 | DSP write data |
| dsp_we | output | 1 | DSP register write enable |
| dsp_re | output | 1 | DSP register read enable |
| dsp_rdata | input | 8 | DSP read data, one cycle after dsp_re |
| timer_en | output | 3 | Timer enables |
| comm_ports | output | 32 | Four communication port bytes, port k at bits 8k+7..8k |

## Verification
The bench fills the whole shadow store while the boot image is on and then toggles the image repeatedly. A design that let those writes reach RAM, or that served stale image bytes after switching off, would return the wrong bytes in the top window or raise `ram_we` where none is allowed. Control writes with clear bits 4 and 5, separately and together, are mixed with port writes, and the port contents are compared on every cycle. A swapped or missing pair clear therefore shows up at once. The bench also tests the edges of the register page: 0x00EF, 0x00F8, 0x00F9 and 0x00FC must go to RAM, the test location must stay inert, and an index with bit 7 set must be masked on `dsp_index`. A decoder with an off-by-one page boundary, or one that dropped the mask, would mis-route those accesses.

// File: rtl/iopage_pkg.sv
package iopage_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    SEL_RAM,
    SEL_ROM,
    SEL_ZERO,
    SEL_DIDX,
    SEL_DDAT,
    SEL_PORT
  } sel_e;

  // Boot image byte for offset i in an image of the given depth.
  function automatic logic [DATA_W-1:0] boot_byte(int unsigned i, int unsigned depth);
    if (i == depth - 2) return 8'hC0;
    if (i == depth - 1) return 8'hFF;
    return 8'((i * 29) ^ 32'hA5);
  endfunction

endpackage

// File: rtl/iopage_decode.sv
module iopage_decode
  import iopage_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_BASE   = 'hF0,
  parameter int ROM_DEPTH = 64,
  parameter int PORT_N    = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output sel_e               sel,
  output logic               is_io,
  output logic               is_rom,
  output logic               ram_mapped,
  output logic [3:0]         io_off,
  output logic [$clog2(ROM_DEPTH)-1:0] rom_off
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam logic [ADDR_W-1:0] IO_BASE_A = ADDR_W'(IO_BASE);
  localparam logic [3:0] PORT_LO = 4'd4;
  localparam logic [4:0] PORT_HI = 5'(4 + PORT_N);

  logic port_hit;

  always_comb begin
    is_io    = (addr[ADDR_W-1:4] == IO_BASE_A[ADDR_W-1:4]);
    is_rom   = &addr[ADDR_W-1:ROM_AW];
    io_off   = addr[3:0];
    rom_off  = addr[ROM_AW-1:0];
    port_hit = (io_off >= PORT_LO) && ({1'b0, io_off} < PORT_HI);

    if (is_rom) begin
      sel = SEL_ROM;
    end else if (!is_io) begin
      sel = SEL_RAM;
    end else if (io_off == 4'd0 || io_off == 4'd1) begin
      sel = SEL_ZERO;
    end else if (io_off == 4'd2) begin
      sel = SEL_DIDX;
    end else if (io_off == 4'd3) begin
      sel = SEL_DDAT;
    end else if (port_hit) begin
      sel = SEL_PORT;
    end else begin
      sel = SEL_RAM;
    end

    ram_mapped = (sel == SEL_RAM);
  end

endmodule

// File: rtl/iopage_regs.sv
module iopage_regs
  import iopage_pkg::*;
#(
  parameter int TMR_N  = 3,
  parameter int PORT_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               io_off,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     rom_en,
  output logic [TMR_N-1:0]         tmr_en,
  output logic [DATA_W-1:0]        dsp_idx,
  output logic [PORT_N*DATA_W-1:0] ports,
  output logic [DATA_W-1:0]        port_rd
);
  localparam int PIDX_W  = (PORT_N > 1) ? $clog2(PORT_N) : 1;
  localparam int ROM_BIT = 7;
  localparam int CLR_LSB = 4;
  localparam logic [3:0] CTRL_OFF = 4'd1;
  localparam logic [3:0] IDX_OFF  = 4'd2;
  localparam logic [3:0] PORT_LO  = 4'd4;
  localparam logic [4:0] PORT_HI  = 5'(4 + PORT_N);

  logic              ctrl_wr, idx_wr, port_wr;
  logic [PIDX_W-1:0] port_sel;
  logic              rom_en_q, rom_en_d;
  logic [TMR_N-1:0]  tmr_q, tmr_d;
  logic [DATA_W-1:0] idx_q, idx_d;
  logic [DATA_W-1:0] port_q [PORT_N];
  logic [DATA_W-1:0] port_d [PORT_N];
  logic [PORT_N-1:0] port_ce;

  // Write decode
  always_comb begin
    ctrl_wr  = wr_en && (io_off == CTRL_OFF);
    idx_wr   = wr_en && (io_off == IDX_OFF);
    port_wr  = wr_en && (io_off >= PORT_LO) && ({1'b0, io_off} < PORT_HI);
    port_sel = PIDX_W'(io_off - PORT_LO);
  end

  // Next state of control and index registers
  always_comb begin
    rom_en_d = wdata[ROM_BIT];
    tmr_d    = wdata[TMR_N-1:0];
    idx_d    = wdata;
  end

  // Per-port next state: a CPU write loads, a pair clear zeroes
  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    logic hit, clr;
    always_comb begin
      hit        = port_wr && (port_sel == PIDX_W'(p));
      clr        = ctrl_wr && wdata[CLR_LSB + p / 2];
      port_ce[p] = hit || clr;
      port_d[p]  = hit ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        port_q[p] <= '0;
      end else if (port_ce[p]) begin
        port_q[p] <= port_d[p];
      end
    end

    assign ports[p*DATA_W +: DATA_W] = port_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_en_q <= 1'b1;
      tmr_q    <= '0;
    end else if (ctrl_wr) begin
      rom_en_q <= rom_en_d;
      tmr_q    <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    rom_en  = rom_en_q;
    tmr_en  = tmr_q;
    dsp_idx = idx_q;
    port_rd = port_q[port_sel];
  end

endmodule

// File: rtl/iopage_rom.sv
module iopage_rom
  import iopage_pkg::*;
#(
  parameter int ROM_DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(ROM_DEPTH)-1:0] off,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         rom_en,
  output logic [DATA_W-1:0]            rd_byte
);
  logic [DATA_W-1:0] image  [ROM_DEPTH];
  logic [DATA_W-1:0] shadow [ROM_DEPTH];

  // Fixed boot image, one constant per location
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_img
    assign image[g] = boot_byte(g, ROM_DEPTH);
  end

  // Shadow store captures every write to the window
  always_ff @(posedge clk) begin
    if (wr_en) begin
      shadow[off] <= wdata;
    end
  end

  always_comb begin
    rd_byte = rom_en ? image[off] : shadow[off];
  end

endmodule

// File: rtl/iopage_ctrl.sv
module iopage_ctrl
  import iopage_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_BASE   = 'hF0,
  parameter int ROM_DEPTH = 64,
  parameter int TMR_N     = 3,
  parameter int PORT_N    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic                     cpu_wr,
  input  logic                     cpu_rd,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_rvalid,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic [DATA_W-1:0]        ram_wdata,
  output logic                     ram_we,
  output logic                     ram_re,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic [DATA_W-2:0]        dsp_index,
  output logic [DATA_W-1:0]        dsp_wdata,
  output logic                     dsp_we,
  output logic                     dsp_re,
  input  logic [DATA_W-1:0]        dsp_rdata,
  output logic [TMR_N-1:0]         timer_en,
  output logic [PORT_N*DATA_W-1:0] comm_ports
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sel_e              sel;
  logic              is_io, is_rom, ram_mapped;
  logic [3:0]        io_off;
  logic [ROM_AW-1:0] rom_off;
  logic              rom_en;
  logic [DATA_W-1:0] dsp_idx;
  logic [DATA_W-1:0] port_rd;
  logic [DATA_W-1:0] rom_byte;
  logic              rd_go;

  iopage_decode #(
    .ADDR_W   (ADDR_W),
    .IO_BASE  (IO_BASE),
    .ROM_DEPTH(ROM_DEPTH),
    .PORT_N   (PORT_N)
  ) decode_i (
    .addr      (cpu_addr),
    .sel       (sel),
    .is_io     (is_io),
    .is_rom    (is_rom),
    .ram_mapped(ram_mapped),
    .io_off    (io_off),
    .rom_off   (rom_off)
  );

  iopage_regs #(
    .TMR_N (TMR_N),
    .PORT_N(PORT_N)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (cpu_wr && is_io),
    .io_off (io_off),
    .wdata  (cpu_wdata),
    .rom_en (rom_en),
    .tmr_en (timer_en),
    .dsp_idx(dsp_idx),
    .ports  (comm_ports),
    .port_rd(port_rd)
  );

  iopage_rom #(
    .ROM_DEPTH(ROM_DEPTH)
  ) rom_i (
    .clk    (clk),
    .wr_en  (cpu_wr && is_rom),
    .off    (rom_off),
    .wdata  (cpu_wdata),
    .rom_en (rom_en),
    .rd_byte(rom_byte)
  );

  // Downstream strobes
  always_comb begin
    rd_go     = cpu_rd && !cpu_wr;
    ram_addr  = cpu_addr;
    ram_wdata = cpu_wdata;
    ram_we    = cpu_wr && (ram_mapped || (is_rom && !rom_en));
    ram_re    = rd_go && ram_mapped;
    dsp_index = dsp_idx[DATA_W-2:0];
    dsp_wdata = cpu_wdata;
    dsp_we    = cpu_wr && (sel == SEL_DDAT);
    dsp_re    = rd_go && (sel == SEL_DDAT);
  end

  // Read return path
  logic              rvalid_q;
  sel_e              src_q;
  logic [DATA_W-1:0] loc_q, loc_d;

  always_comb begin
    unique case (sel)
      SEL_ROM:  loc_d = rom_byte;
      SEL_DIDX: loc_d = dsp_idx;
      SEL_PORT: loc_d = port_rd;
      default:  loc_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      src_q <= SEL_ZERO;
      loc_q <= '0;
    end else if (rd_go) begin
      src_q <= sel;
      loc_q <= loc_d;
    end
  end

  always_comb begin
    cpu_rvalid = rvalid_q;
    unique case (src_q)
      SEL_RAM:  cpu_rdata = ram_rdata;
      SEL_DDAT: cpu_rdata = dsp_rdata;
      default:  cpu_rdata = loc_q;
    endcase
  end

endmodule

// File: rtl/iopage_ctrl_chk.sv
module iopage_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int IO_BASE   = 'hF0,
  parameter int ROM_DEPTH = 64,
  parameter int TMR_N     = 3,
  parameter int PORT_N    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic [7:0]           cpu_wdata,
  input logic                 cpu_wr,
  input logic                 cpu_rd,
  input logic                 cpu_rvalid,
  input logic                 ram_we,
  input logic                 dsp_we,
  input logic [TMR_N-1:0]     timer_en,
  input logic [PORT_N*8-1:0]  comm_ports,
  input logic                 rom_en
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(IO_BASE + 1);

  logic in_top;
  assign in_top = (cpu_addr >= ADDR_W'((1 << ADDR_W) - ROM_DEPTH));

  AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> cpu_rvalid); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && !cpu_wr) |=> !cpu_rvalid); // R10
  AST_ROM_WRITE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_top && rom_en) |-> !ram_we); // R3
  AST_ROM_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_top && !rom_en) |-> ram_we); // R3
  AST_TEST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == TEST_A) |-> (!ram_we && !dsp_we)); // R8
  AST_TEST_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == TEST_A) |=> ($stable(timer_en) && $stable(comm_ports) && $stable(rom_en))); // R8
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_A) |=> (timer_en == $past(cpu_wdata[TMR_N-1:0]))); // R5
  AST_ROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_A) |=> (rom_en == $past(cpu_wdata[7]))); // R5
  AST_CLEAR_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_A && cpu_wdata[4]) |=> (comm_ports[15:0] == 16'h0)); // R6
  AST_CLEAR_HIGH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_A && cpu_wdata[5]) |=> (comm_ports[31:16] == 16'h0)); // R6
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, dsp_we})); // R7

endmodule

bind iopage_ctrl iopage_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .IO_BASE  (IO_BASE),
  .ROM_DEPTH(ROM_DEPTH),
  .TMR_N    (TMR_N),
  .PORT_N   (PORT_N)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .cpu_rvalid(cpu_rvalid),
  .ram_we    (ram_we),
  .dsp_we    (dsp_we),
  .timer_en  (timer_en),
  .comm_ports(comm_ports),
  .rom_en    (rom_en)
);

// File: tb/iopage_ctrl_tb.sv
`timescale 1ns/1ps
module iopage_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we, ram_re;
  logic [7:0]  ram_rdata = '0;
  logic [6:0]  dsp_index;
  logic [7:0]  dsp_wdata;
  logic        dsp_we, dsp_re;
  logic [7:0]  dsp_rdata = '0;
  logic [2:0]  timer_en;
  logic [31:0] comm_ports;

  always #2.5 clk = ~clk;

  iopage_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata),
    .dsp_index(dsp_index), .dsp_wdata(dsp_wdata), .dsp_we(dsp_we), .dsp_re(dsp_re),
    .dsp_rdata(dsp_rdata),
    .timer_en(timer_en), .comm_ports(comm_ports)
  );

  // Environment: external RAM and DSP register file
  logic [7:0] env_mem [int];
  logic [7:0] env_dsp [128];

  function automatic logic [7:0] env_get(int a);
    if (env_mem.exists(a)) return env_mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (ram_re) ram_rdata <= env_get(int'(ram_addr));
    if (ram_we) env_mem[int'(ram_addr)] = ram_wdata;
    if (dsp_re) dsp_rdata <= env_dsp[dsp_index];
    if (dsp_we) env_dsp[dsp_index] = dsp_wdata;
  end

  // Reference model state
  logic [7:0] m_mem [int];
  logic [7:0] m_dsp [128];
  logic [7:0] m_shadow [64];
  logic [7:0] m_port [4];
  logic [2:0] m_tmr;
  logic [7:0] m_idx;
  bit         m_rom_on;
  bit         exp_rv;
  logic [7:0] exp_rd;
  string      exp_tag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] m_get(int a);
    if (m_mem.exists(a)) return m_mem[a];
    return 8'h00;
  endfunction

  function automatic logic [7:0] image_byte(int i);
    if (i == 62) return 8'hC0;
    if (i == 63) return 8'hFF;
    return 8'(((29 * i) % 256) ^ 8'hA5);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [15:0] a);
    if (a >= 16'hFFC0) return "R4";
    if (a == 16'h00F0 || a == 16'h00F1) return "R8";
    if (a == 16'h00F2 || a == 16'h00F3) return "R7";
    if (a >= 16'h00F4 && a <= 16'h00F7) return "R6";
    return "R9";
  endfunction

  function automatic logic [7:0] model_read(logic [15:0] a);
    if (a >= 16'hFFC0) return m_rom_on ? image_byte(int'(a - 16'hFFC0)) : m_shadow[a - 16'hFFC0];
    if (a == 16'h00F0 || a == 16'h00F1) return 8'h00;
    if (a == 16'h00F2) return m_idx;
    if (a == 16'h00F3) return m_dsp[m_idx[6:0]];
    if (a >= 16'h00F4 && a <= 16'h00F7) return m_port[a - 16'h00F4];
    return m_get(int'(a));
  endfunction

  // One bus cycle: compare everything, then drive the next access
  task automatic op(bit w, bit r, logic [15:0] a, logic [7:0] d);
    bit ewe, ere, edwe, edre;
    @(negedge clk);
    chk("R10", "rvalid", int'(cpu_rvalid), int'(exp_rv));
    if (exp_rv) chk(exp_tag, "rdata", int'(cpu_rdata), int'(exp_rd));
    chk("R5", "timer_en", int'(timer_en), int'(m_tmr));
    chk("R6", "comm_ports", int'(comm_ports), int'({m_port[3], m_port[2], m_port[1], m_port[0]}));
    chk("R7", "dsp_index", int'(dsp_index), int'(m_idx[6:0]));

    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d;
    exp_rv = r && !w;
    if (exp_rv) begin
      exp_rd  = model_read(a);
      exp_tag = (a >= 16'hFFC0 && m_rom_on) ? "R2" : tag_of(a);
    end
    ewe  = w && ((a < 16'h00F0) || (a >= 16'h00F8 && a < 16'hFFC0) || (a >= 16'hFFC0 && !m_rom_on));
    ere  = exp_rv && ((a < 16'h00F0) || (a >= 16'h00F8 && a < 16'hFFC0));
    edwe = w && (a == 16'h00F3);
    edre = exp_rv && (a == 16'h00F3);
    #1;
    chk((a >= 16'hFFC0) ? "R3" : (a == 16'h00F0 ? "R8" : "R9"), "ram_we", int'(ram_we), int'(ewe));
    chk("R9", "ram_re", int'(ram_re), int'(ere));
    chk("R7", "dsp_we", int'(dsp_we), int'(edwe));
    chk("R7", "dsp_re", int'(dsp_re), int'(edre));

    if (w) begin
      if (a >= 16'hFFC0) begin
        m_shadow[a - 16'hFFC0] = d;
        if (!m_rom_on) m_mem[int'(a)] = d;
      end else if (a == 16'h00F0) begin
      end else if (a == 16'h00F1) begin
        m_tmr = d[2:0];
        m_rom_on = d[7];
        if (d[4]) begin m_port[0] = 8'h00; m_port[1] = 8'h00; end
        if (d[5]) begin m_port[2] = 8'h00; m_port[3] = 8'h00; end
      end else if (a == 16'h00F2) begin
        m_idx = d;
      end else if (a == 16'h00F3) begin
        m_dsp[m_idx[6:0]] = d;
      end else if (a >= 16'h00F4 && a <= 16'h00F7) begin
        m_port[a - 16'h00F4] = d;
      end else begin
        m_mem[int'(a)] = d;
      end
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d); op(1'b1, 1'b0, a, d); endtask
  task automatic rd(logic [15:0] a); op(1'b0, 1'b1, a, 8'h00); endtask
  task automatic idle(); op(1'b0, 1'b0, 16'h0000, 8'h00); endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      env_dsp[i] = 8'(i * 3 + 1);
      m_dsp[i]   = 8'(i * 3 + 1);
    end
    for (int i = 0; i < 4; i++) m_port[i] = 8'h00;
    m_tmr = 3'd0; m_idx = 8'h00; m_rom_on = 1'b1; exp_rv = 1'b0; exp_rd = 8'h00; exp_tag = "R10";

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1: reset state
    chk("R1", "reset timer_en", int'(timer_en), 0);
    chk("R1", "reset comm_ports", int'(comm_ports), 0);
    chk("R1", "reset dsp_index", int'(dsp_index), 0);
    rd(16'hFFC0);
    idle();
    chk("R1", "reset boot image on", int'(cpu_rdata), int'(image_byte(0)));

    // R2: image reads, including the top two bytes
    rd(16'hFFC0); rd(16'hFFD5); rd(16'hFFFE); rd(16'hFFFF); idle();

    // R3: fill every shadow byte while the image is on
    for (int i = 0; i < 64; i++) wr(16'hFFC0 + 16'(i), 8'(i ^ 8'h3C));
    rd(16'hFFC4);

    // R5 and R4: image off, shadow visible, writes go through
    wr(16'h00F1, 8'h05);
    rd(16'hFFC4); rd(16'hFFFF);
    wr(16'hFFC8, 8'h33);
    rd(16'hFFC8);
    wr(16'h00F1, 8'h80);
    rd(16'hFFC8); rd(16'hFFFE);
    wr(16'h00F1, 8'h02);
    rd(16'hFFC8);
    wr(16'h00F1, 8'h80);

    // R6: ports and pair clears
    wr(16'h00F4, 8'h11); wr(16'h00F5, 8'h22); wr(16'h00F6, 8'h33); wr(16'h00F7, 8'h44);
    rd(16'h00F4); rd(16'h00F7);
    wr(16'h00F1, 8'h90);
    rd(16'h00F5); rd(16'h00F6);
    wr(16'h00F4, 8'hA1); wr(16'h00F5, 8'hA2);
    wr(16'h00F1, 8'hA0);
    rd(16'h00F4); rd(16'h00F7);
    wr(16'h00F6, 8'h5E);
    wr(16'h00F1, 8'hB7);
    idle();

    // R7: DSP index and data
    wr(16'h00F2, 8'h85);
    rd(16'h00F2); rd(16'h00F3);
    wr(16'h00F3, 8'h77);
    rd(16'h00F3);
    wr(16'h00F2, 8'h10);
    rd(16'h00F3);

    // R8: test location and zero reads
    wr(16'h00F0, 8'hFF);
    idle();
    rd(16'h00F0); rd(16'h00F1);

    // R9: RAM-mapped locations at the page edges
    wr(16'h0010, 8'h9A); wr(16'h00EF, 8'h01); wr(16'h00F8, 8'h02);
    wr(16'h00F9, 8'h03); wr(16'h00FC, 8'h04); wr(16'h1234, 8'h05); wr(16'hFFBF, 8'h06);
    rd(16'h0010); rd(16'h00EF); rd(16'h00F8); rd(16'h00F9);
    rd(16'h00FC); rd(16'h1234); rd(16'hFFBF);

    // R10: both strobes together act as a write
    op(1'b1, 1'b1, 16'h0020, 8'h6D);
    rd(16'h0020);

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int pick;
      pick = (i * 7 + i / 10) % 10;
      d = 8'(i * 37 + 11);
      case (pick)
        0: a = 16'h00F1;
        1: a = 16'h00F2;
        2: a = 16'h00F3;
        3: a = 16'h00F4;
        4: a = 16'h00F5;
        5: a = 16'h00F6;
        6: a = 16'h00F7;
        7: a = 16'h00F8;
        8: a = 16'hFFC0 + 16'(i % 64);
        default: a = 16'h0040 + 16'(i % 8);
      endcase
      if (i % 3 == 0) rd(a);
      else wr(a, d);
    end
    idle(); idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule